// File: doc/BRIEF.md
# Host-Bus Register Bank

This block lets a host processor see the FPGA as a small word-addressed memory over an asynchronous parallel bus. The bus has an address, a shared bidirectional 16-bit data bus, and three active-low strobes: select, write and read. The host can store words in the writable locations and read them back. Two read-only locations reflect live signals from elsewhere in the chip, an encoder position count and a motor PWM duty value, so software can log them while the control loop runs.

The select and write strobes come from another clock domain, so each passes through a two-flop synchroniser. A write takes effect on the rising edge of the synchronised write strobe, and only if the synchronised select is low at that moment. Reads are combinational from the pins. The block drives the data pins only while select and read are both low. At all other times it leaves them at high impedance, so other devices on the bus can drive them.

Top module: `hostbus_regbank`

## Requirements
- R1: After reset every writable location (address 2 and above) reads as zero.
- R2: The data pins are released (high impedance) unless both the select and read strobes are low; with either strobe high, a value driven by another device is seen unchanged.
- R3: A read of address 0 returns the current encoder count input, and follows changes of that input without any clock edge.
- R4: A read of address 1 returns the current PWM duty input.
- R5: A write to an address of 2 or above stores the data that is on the pins when the synchronised write strobe rises while the synchronised select is low.
- R6: Writes to addresses 0 and 1 change no stored location.
- R7: A write strobe given while the select is high changes no stored location.
- R8: A write becomes visible on the third rising clock edge after the write strobe rises at the pins, and not on the second.
- R9: Every writable location keeps its own value: after distinct words are written to all of them, each reads back its own word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | FPGA clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_addr | input | ADDR_W | Word address from the host |
| hb_data | inout | DATA_W | Shared bidirectional data bus |
| hb_sel_n | input | 1 | Active-low chip select |
| hb_wr_n | input | 1 | Active-low write strobe |
| hb_rd_n | input | 1 | Active-low read (output enable) strobe |
| enc_count | input | DATA_W | Live encoder count, shown at address 0 |
| pwm_duty | input | DATA_W | Live PWM duty, shown at address 1 |

## Verification
Reads are combinational, so the bench samples the data pins 1 ns after it sets address and strobes, with no clock edge in between. A write lands on the third rising edge after the write strobe rises: two synchroniser stages plus the commit register. The bench holds address, data and select stable for four edges after raising the strobe, and only then reads back. For the latency requirement it reads after exactly two edges, where it expects the old value, and again after the third, where it expects the new one.

// File: rtl/hostbus_regbank.sv
module hostbus_regbank #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] hb_addr,
  inout  wire  [DATA_W-1:0] hb_data,
  input  logic              hb_sel_n,
  input  logic              hb_wr_n,
  input  logic              hb_rd_n,
  input  logic [DATA_W-1:0] enc_count,
  input  logic [DATA_W-1:0] pwm_duty
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] FIRST_RW = ADDR_W'(2);

  logic sel_q1, sel_q2;
  logic wr_q1, wr_q2, wr_q3;
  logic [DEPTH*DATA_W-1:0] mem_flat;
  logic [DATA_W-1:0] rd_word;
  logic wr_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q1 <= 1'b1;
      sel_q2 <= 1'b1;
      wr_q1  <= 1'b1;
      wr_q2  <= 1'b1;
      wr_q3  <= 1'b1;
    end else begin
      sel_q1 <= hb_sel_n;
      sel_q2 <= sel_q1;
      wr_q1  <= hb_wr_n;
      wr_q2  <= wr_q1;
      wr_q3  <= wr_q2;
    end
  end

  assign wr_fire = wr_q2 & ~wr_q3 & ~sel_q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mem_flat <= '0;
    else if (wr_fire && hb_addr >= FIRST_RW)
      mem_flat[int'(hb_addr)*DATA_W +: DATA_W] <= hb_data;
  end

  always_comb begin
    case (hb_addr)
      ADDR_W'(0): rd_word = enc_count;
      ADDR_W'(1): rd_word = pwm_duty;
      default:    rd_word = mem_flat[int'(hb_addr)*DATA_W +: DATA_W];
    endcase
  end

  assign hb_data = (!hb_sel_n && !hb_rd_n) ? rd_word : {DATA_W{1'bz}};

  function automatic logic [DATA_W-1:0] word_at(input logic [ADDR_W-1:0] a);
    return mem_flat[int'(a)*DATA_W +: DATA_W];
  endfunction

  // R5
  write_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && hb_addr >= FIRST_RW) |=> word_at($past(hb_addr)) == $past(hb_data));

  // R6
  ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && hb_addr < FIRST_RW) |=> $stable(mem_flat));

  // R7
  unselected_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q2 |=> $stable(mem_flat));

  // R8
  no_early_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_q1) |-> !wr_fire);

endmodule

// File: tb/hostbus_regbank_tb.sv
module hostbus_regbank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NWORDS = 1 << AW;

  logic clk = 0;
  logic rst_n = 0;
  logic [AW-1:0] hb_addr = '0;
  logic hb_sel_n = 1, hb_wr_n = 1, hb_rd_n = 1;
  logic [DW-1:0] enc_count = '0, pwm_duty = '0;
  logic tb_drv = 0;
  logic [DW-1:0] tb_val = '0;
  wire  [DW-1:0] hb_data;
  int checks = 0, fails = 0;
  bit done = 0;

  assign hb_data = tb_drv ? tb_val : {DW{1'bz}};

  always #(CLK_PERIOD/2) clk = ~clk;

  hostbus_regbank #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .hb_addr(hb_addr), .hb_data(hb_data),
    .hb_sel_n(hb_sel_n), .hb_wr_n(hb_wr_n), .hb_rd_n(hb_rd_n),
    .enc_count(enc_count), .pwm_duty(pwm_duty));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'((a * 16'h1357) ^ (k * 16'h2468) ^ 16'h0F0F);
  endfunction

  task automatic bus_read(input int a, output logic [DW-1:0] v);
    @(negedge clk);
    hb_addr = AW'(a); hb_sel_n = 0; hb_rd_n = 0;
    #1 v = hb_data;
    hb_rd_n = 1; hb_sel_n = 1;
  endtask

  task automatic bus_write(input int a, input logic [DW-1:0] d, input bit sel);
    @(negedge clk);
    hb_addr = AW'(a); tb_val = d; tb_drv = 1; hb_sel_n = !sel;
    @(negedge clk); hb_wr_n = 0;
    repeat (2) @(negedge clk);
    hb_wr_n = 1;
    repeat (4) @(negedge clk);
    hb_sel_n = 1; tb_drv = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_all(input string req, input int k);
    logic [DW-1:0] v;
    for (int a = 2; a < NWORDS; a++) begin
      bus_read(a, v);
      chk(req, v, (k < 0) ? '0 : pat(a, k));
    end
  endtask

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    check_all("R1", -1);

    enc_count = 16'h1234; bus_read(0, v); chk("R3", v, 16'h1234);
    @(negedge clk); hb_addr = 0; hb_sel_n = 0; hb_rd_n = 0;
    #1 enc_count = 16'hBEEF; #1 chk("R3", hb_data, 16'hBEEF);
    hb_rd_n = 1; hb_sel_n = 1;
    pwm_duty = 16'h03E8; bus_read(1, v); chk("R4", v, 16'h03E8);
    pwm_duty = 16'hFC18; bus_read(1, v); chk("R4", v, 16'hFC18);

    enc_count = 16'hA5C3;
    for (int m = 0; m < 3; m++) begin
      @(negedge clk);
      hb_addr = 0; tb_val = 16'h5A3C; tb_drv = 1;
      hb_sel_n = (m == 1); hb_rd_n = (m != 1);
      if (m == 2) hb_sel_n = 1;
      #1 chk("R2", hb_data, 16'h5A3C);
      tb_drv = 0; hb_sel_n = 1; hb_rd_n = 1;
    end

    for (int a = 2; a < NWORDS; a++) bus_write(a, pat(a, 1), 1);
    check_all("R9", 1);
    bus_write(5, 16'hC0DE, 1); bus_read(5, v); chk("R5", v, 16'hC0DE);
    bus_write(5, pat(5, 1), 1);

    bus_write(0, 16'hFFFF, 1); bus_write(1, 16'h7777, 1);
    check_all("R6", 1);
    bus_read(1, v); chk("R6", v, 16'hFC18);

    for (int a = 2; a < NWORDS; a++) bus_write(a, 16'hDEAD, 0);
    check_all("R7", 1);

    @(negedge clk);
    hb_addr = 7; tb_val = 16'h4321; tb_drv = 1; hb_sel_n = 0;
    @(negedge clk); hb_wr_n = 0;
    repeat (2) @(negedge clk);
    hb_wr_n = 1;
    repeat (2) @(negedge clk);
    tb_drv = 0; hb_rd_n = 0;
    #1 chk("R8", hb_data, pat(7, 1));
    hb_rd_n = 1; tb_drv = 1;
    @(negedge clk);
    tb_drv = 0; hb_rd_n = 0;
    #1 chk("R8", hb_data, 16'h4321);
    hb_rd_n = 1; hb_sel_n = 1;
    repeat (3) @(negedge clk);

    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; repeat (2) @(negedge clk);
    check_all("R1", -1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule